// File: doc/BRIEF.md
# Six-Phase Strip-Hit Trigger Sequencer

This block sits between the per-layer strip discriminators and the pattern-search logic of a track trigger. Every enabled clock it widens each incoming half-strip hit into a short pulse, so that layers with slower drift still overlap in time. It then hands the pattern logic a 64-bit window per layer. While idle it sits in a scan phase and presents live coarse bits. A coarse bit is the OR of four neighbouring half-strips.

When the pattern logic reports a pretrigger, the sequencer waits a configurable number of settling clocks. It then freezes a snapshot of all stretched hits and walks through five more phases. The first of these presents the frozen coarse bits again, for the best-pattern pass. The other four present the frozen half-strip bits, one quarter of the window per phase. After the last phase it returns to scan.

The data path is a real-time sample stream with no back-pressure. A hit is taken on every enabled clock and cannot be stalled or refused. For that reason the block edge carries no valid/ready handshake; a downstream consumer that needs to pause must gate `ce_i`. The pretrigger, the phase code and the latch-valid flag are plain level signals.

Top module: `trig_phase_seq`

## Requirements
- R1: Phase codes are 1 for scan, 0 for settling, and 2 to 6 for the processing phases. While reset is asserted, and right after it, the phase is 1, `latch_vld_o` is 0 and `hits_o` is all zero.
- R2: In phase 1 with `ce_i` high and `pretrig_i` low, the phase stays 1.
- R3: In phase 1, an enabled clock with `pretrig_i` high moves to phase 0. The phase stays 0 for `SETTLE_CLKS` enabled clocks (default 2) and then becomes 2. With `SETTLE_CLKS` = 0 it goes straight to phase 2.
- R4: Phases 2, 3, 4, 5 and 6 each last exactly one enabled clock, in that order, and phase 6 is followed by phase 1.
- R5: `pretrig_i` has no effect outside phase 1.
- R6: While `ce_i` is low, the phase, the settle count and the hit stretchers all hold their values. A hit presented during a disabled clock is not captured.
- R7: A half-strip hit that is high at an enabled clock edge appears as stretched for the following 3 enabled clocks (`STRETCH_CLKS`).
- R8: In phases 1 and 0, bit `L*64+c` of `hits_o` is the OR of the stretched half-strips `4c` to `4c+3` of layer `L`. Half-strip `h` of layer `L` is input bit `L*256+h`.
- R9: On the clock that enters phase 2, all stretched hits are captured. The capture is held unchanged through phase 6, and later input hits do not alter it.
- R10: Phase 2 outputs the coarse OR (as in R8) of the capture. Phase `k` in 3 to 6 outputs bit `L*64+j` equal to captured half-strip `(k-3)*64+j` of layer `L`.
- R11: `latch_vld_o` is high exactly when the phase is 2 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Clock enable for all state |
| pretrig_i | input | 1 | Pretrigger reported by the pattern logic |
| hs_hit_i | input | 1536 | Half-strip hits, 256 per layer, layer L at bits L*256 upward |
| phase_o | output | 3 | Current phase code |
| hits_o | output | 384 | Window presented to pattern logic, 64 per layer |
| latch_vld_o | output | 1 | High while the captured snapshot is being presented |

## Verification
On every cycle the checker confirms the legal phase codes, the stay-or-leave rule of the scan phase, the strict 2-to-6 ordering and wrap, the freeze under a low enable, the upper bound on the settle length, and the tie between the latch-valid flag and the phase. The data-side behaviour can only be shown by the bench's scenarios: the three-clock stretch, the coarse OR grouping, the quarter selection in phases 3 to 6, and the snapshot staying immune to later hits. The bench also shows that a pretrigger raised during settling or processing changes nothing.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  localparam int HS_PER_COARSE = 4;  // one coarse bit spans four half-strips

  typedef enum logic [2:0] {
    PH_SETTLE = 3'd0,
    PH_SCAN   = 3'd1,
    PH_BEST   = 3'd2,
    PH_HS0    = 3'd3,
    PH_HS1    = 3'd4,
    PH_HS2    = 3'd5,
    PH_HS3    = 3'd6
  } phase_e;
endpackage

// File: rtl/hit_stretch.sv
module hit_stretch #(
  parameter int W     = 256,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [W-1:0] hit_i,
  output logic [W-1:0] str_o
);
  logic [DEPTH-1:0][W-1:0] sh_q;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  sh_q <= '0;
        else if (ce) sh_q[0] <= hit_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  sh_q <= '0;
        else if (ce) sh_q <= {sh_q[DEPTH-2:0], hit_i};
      end
    end
  endgenerate

  // A hit is seen as long as it is still in any stage of the delay line.
  always_comb begin
    str_o = '0;
    for (int d = 0; d < DEPTH; d++) str_o = str_o | sh_q[d];
  end
endmodule

// File: rtl/phase_ctrl.sv
module phase_ctrl
  import trig_seq_pkg::*;
#(
  parameter int SETTLE_CLKS = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ce,
  input  logic   pretrig,
  output phase_e phase,
  output logic   cap_en
);
  localparam int CNT_W = (SETTLE_CLKS > 1) ? $clog2(SETTLE_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'((SETTLE_CLKS > 0) ? SETTLE_CLKS - 1 : 0);

  phase_e          ph_q, ph_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    ph_n   = ph_q;
    cnt_n  = cnt_q;
    cap_en = 1'b0;
    if (ce) begin
      case (ph_q)
        PH_SCAN: begin
          if (pretrig) begin
            if (SETTLE_CLKS == 0) begin
              ph_n   = PH_BEST;
              cap_en = 1'b1;
            end else begin
              ph_n  = PH_SETTLE;
              cnt_n = CNT_LOAD;
            end
          end
        end
        PH_SETTLE: begin
          if (cnt_q == '0) begin
            ph_n   = PH_BEST;
            cap_en = 1'b1;
          end else begin
            cnt_n = cnt_q - 1'b1;
          end
        end
        PH_BEST: ph_n = PH_HS0;
        PH_HS0:  ph_n = PH_HS1;
        PH_HS1:  ph_n = PH_HS2;
        PH_HS2:  ph_n = PH_HS3;
        PH_HS3:  ph_n = PH_SCAN;
        default: ph_n = PH_SCAN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_SCAN;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_n;
      cnt_q <= cnt_n;
    end
  end

  assign phase = ph_q;
endmodule

// File: rtl/window_sel.sv
module window_sel
  import trig_seq_pkg::*;
#(
  parameter int NL = 6,
  parameter int CW = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cap_en,
  input  phase_e                        phase,
  input  logic [NL*CW*HS_PER_COARSE-1:0] str_i,
  output logic [NL*CW-1:0]              win_o
);
  localparam int HSW = CW * HS_PER_COARSE;
  localparam int NQ  = HS_PER_COARSE;

  logic [NL*HSW-1:0]         cap_q;
  logic [NL*HSW-1:0]         src;
  logic [NL*CW-1:0]          crs;
  logic [NQ-1:0][NL*CW-1:0]  qsl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_en) cap_q <= str_i;
  end

  // Coarse bits come from live hits before capture, from the snapshot after.
  assign src = (phase == PH_SCAN || phase == PH_SETTLE) ? str_i : cap_q;

  generate
    for (genvar l = 0; l < NL; l++) begin : g_lay
      for (genvar c = 0; c < CW; c++) begin : g_crs
        assign crs[l*CW+c] = |src[l*HSW + c*HS_PER_COARSE +: HS_PER_COARSE];
      end
      for (genvar q = 0; q < NQ; q++) begin : g_q
        assign qsl[q][l*CW +: CW] = cap_q[l*HSW + q*CW +: CW];
      end
    end
  endgenerate

  always_comb begin
    case (phase)
      PH_HS0:  win_o = qsl[0];
      PH_HS1:  win_o = qsl[1];
      PH_HS2:  win_o = qsl[2];
      PH_HS3:  win_o = qsl[3];
      default: win_o = crs;
    endcase
  end
endmodule

// File: rtl/trig_phase_seq.sv
module trig_phase_seq
  import trig_seq_pkg::*;
#(
  parameter int NUM_LAYERS   = 6,
  parameter int COARSE_W     = 64,
  parameter int STRETCH_CLKS = 3,
  parameter int SETTLE_CLKS  = 2
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        ce_i,
  input  logic                                        pretrig_i,
  input  logic [NUM_LAYERS*COARSE_W*HS_PER_COARSE-1:0] hs_hit_i,
  output logic [2:0]                                  phase_o,
  output logic [NUM_LAYERS*COARSE_W-1:0]              hits_o,
  output logic                                        latch_vld_o
);
  localparam int HSW = COARSE_W * HS_PER_COARSE;

  logic [NUM_LAYERS*HSW-1:0] str;
  phase_e                    phase;
  logic                      cap_en;

  generate
    for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_str
      hit_stretch #(.W(HSW), .DEPTH(STRETCH_CLKS)) u_str (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce_i),
        .hit_i (hs_hit_i[l*HSW +: HSW]),
        .str_o (str[l*HSW +: HSW])
      );
    end
  endgenerate

  phase_ctrl #(.SETTLE_CLKS(SETTLE_CLKS)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce      (ce_i),
    .pretrig (pretrig_i),
    .phase   (phase),
    .cap_en  (cap_en)
  );

  window_sel #(.NL(NUM_LAYERS), .CW(COARSE_W)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (cap_en),
    .phase  (phase),
    .str_i  (str),
    .win_o  (hits_o)
  );

  assign phase_o     = phase;
  assign latch_vld_o = (phase != PH_SCAN) && (phase != PH_SETTLE);
endmodule

// File: rtl/trig_phase_seq_chk.sv
module trig_phase_seq_chk #(
  parameter int SETTLE_CLKS = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_i,
  input logic       pretrig_i,
  input logic [2:0] phase_o,
  input logic       latch_vld_o
);
  logic [15:0] settle_seen;

  // Counts enabled clocks spent in the settle phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        settle_seen <= '0;
    else if (phase_o != 3'd0)          settle_seen <= '0;
    else if (ce_i)                     settle_seen <= settle_seen + 16'd1;
  end

  p_legal_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o <= 3'd6);

  p_scan_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd1 && ce_i && !pretrig_i) |=> phase_o == 3'd1);

  p_scan_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd1 && ce_i && pretrig_i) |=>
      phase_o == ((SETTLE_CLKS == 0) ? 3'd2 : 3'd0));

  p_settle_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o == 3'd0 |-> settle_seen < 16'(SETTLE_CLKS));

  // Ordering also shows that a pretrigger cannot divert the walk (R5).
  p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o >= 3'd2 && phase_o <= 3'd5 && ce_i) |=> phase_o == $past(phase_o) + 3'd1);

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd6 && ce_i) |=> phase_o == 3'd1);

  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_i |=> $stable(phase_o));

  p_vld_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
    latch_vld_o == (phase_o >= 3'd2 && phase_o <= 3'd6));
endmodule

bind trig_phase_seq trig_phase_seq_chk #(.SETTLE_CLKS(SETTLE_CLKS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ce_i        (ce_i),
  .pretrig_i   (pretrig_i),
  .phase_o     (phase_o),
  .latch_vld_o (latch_vld_o)
);

// File: tb/trig_phase_seq_bench.sv
module trig_phase_seq_bench;
  localparam int NL  = 6;
  localparam int CW  = 64;
  localparam int HSW = 256;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ce = 1'b0;
  logic              pt = 1'b0;
  logic [NL*HSW-1:0] hs = '0;
  logic [2:0]        phase;
  logic [NL*CW-1:0]  win;
  logic              vld;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  trig_phase_seq u_trig_phase_seq (
    .clk (clk), .rst_n (rst_n), .ce_i (ce), .pretrig_i (pt),
    .hs_hit_i (hs), .phase_o (phase), .hits_o (win), .latch_vld_o (vld)
  );

  // Row bits: {pretrig, ce, expected phase[2:0], expected latch_vld}
  localparam int NROWS = 21;
  localparam logic [5:0] TBL [NROWS] = '{
    {1'b0,1'b1,3'd1,1'b0}, {1'b0,1'b1,3'd1,1'b0}, {1'b1,1'b1,3'd0,1'b0},
    {1'b0,1'b1,3'd0,1'b0}, {1'b1,1'b1,3'd2,1'b1}, {1'b1,1'b0,3'd2,1'b1},
    {1'b1,1'b1,3'd3,1'b1}, {1'b0,1'b1,3'd4,1'b1}, {1'b1,1'b1,3'd5,1'b1},
    {1'b0,1'b1,3'd6,1'b1}, {1'b0,1'b1,3'd1,1'b0}, {1'b1,1'b0,3'd1,1'b0},
    {1'b1,1'b1,3'd0,1'b0}, {1'b0,1'b0,3'd0,1'b0}, {1'b0,1'b1,3'd0,1'b0},
    {1'b0,1'b1,3'd2,1'b1}, {1'b0,1'b1,3'd3,1'b1}, {1'b0,1'b1,3'd4,1'b1},
    {1'b0,1'b1,3'd5,1'b1}, {1'b0,1'b1,3'd6,1'b1}, {1'b0,1'b1,3'd1,1'b0}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_ctl(string tag, logic [2:0] ep, logic ev);
    checks++;
    if (phase !== ep || vld !== ev) begin
      errors++;
      $display("FAIL %s: phase=%0d vld=%0b expected phase=%0d vld=%0b", tag, phase, vld, ep, ev);
    end
  endtask

  task automatic chk_win(string tag, logic [NL*CW-1:0] ew);
    checks++;
    if (win !== ew) begin
      errors++;
      $display("FAIL %s: hits=%h expected %h", tag, win, ew);
    end
  endtask

  function automatic logic [NL*CW-1:0] coarse_of(logic [NL*HSW-1:0] v);
    logic [NL*CW-1:0] r = '0;
    for (int l = 0; l < NL; l++)
      for (int c = 0; c < CW; c++)
        r[l*CW+c] = |v[l*HSW + c*4 +: 4];
    return r;
  endfunction

  function automatic logic [NL*CW-1:0] quarter_of(logic [NL*HSW-1:0] v, int q);
    logic [NL*CW-1:0] r = '0;
    for (int l = 0; l < NL; l++)
      for (int j = 0; j < CW; j++)
        r[l*CW+j] = v[l*HSW + q*CW + j];
    return r;
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [NL*HSW-1:0] snap;
    logic [NL*HSW-1:0] one;
    // R1: reset state
    #20;
    chk_ctl("R1 reset ctl", 3'd1, 1'b0);
    chk_win("R1 reset data", '0);
    rst_n = 1'b1;
    step();
    chk_ctl("R1 after reset", 3'd1, 1'b0);

    // Table walk: R2 R3 R4 R5 R6 R11 control behaviour
    for (int i = 0; i < NROWS; i++) begin
      pt = TBL[i][5];
      ce = TBL[i][4];
      step();
      chk_ctl($sformatf("R2/R3/R4/R5/R6/R11 row %0d", i), TBL[i][3:1], TBL[i][0]);
    end
    pt = 1'b0;
    ce = 1'b1;

    // R7 and R8: stretch length and coarse grouping in scan
    one = '0;
    one[3*HSW + 9] = 1'b1;
    one[3*HSW + 11] = 1'b1;
    one[5*HSW + 252] = 1'b1;
    hs = one;
    step();
    hs = '0;
    chk_win("R8 coarse grouping", coarse_of(one));
    step();
    chk_win("R7 stretch clk2", coarse_of(one));
    step();
    chk_win("R7 stretch clk3", coarse_of(one));
    step();
    chk_win("R7 stretch ended", '0);

    // R6: disabled clocks freeze the stretcher and ignore new hits
    one = '0;
    one[2*HSW + 100] = 1'b1;
    hs = one;
    step();
    ce = 1'b0;
    hs[4*HSW + 0] = 1'b1;
    hs[2*HSW + 100] = 1'b0;
    step(); step(); step();
    chk_win("R6 frozen stretch", coarse_of(one));
    hs = '0;
    ce = 1'b1;
    step();
    chk_win("R6 resumed clk2", coarse_of(one));
    step();
    chk_win("R6 resumed clk3", coarse_of(one));
    step();
    chk_win("R6 disabled hit not taken", '0);

    // R9 and R10: capture and per-phase presentation
    snap = '0;
    snap[2*HSW + 5]   = 1'b1;
    snap[4*HSW + 130] = 1'b1;
    snap[0*HSW + 255] = 1'b1;
    snap[1*HSW + 70]  = 1'b1;
    hs = snap;
    pt = 1'b1;
    step();
    hs = '0;
    pt = 1'b0;
    chk_ctl("R3 settle entered", 3'd0, 1'b0);
    chk_win("R8 live coarse in settle", coarse_of(snap));
    step();
    step();
    chk_ctl("R3 settle done", 3'd2, 1'b1);
    chk_win("R10 best phase coarse", coarse_of(snap));
    hs[1*HSW + 0] = 1'b1;
    pt = 1'b1;
    step();
    hs = '0;
    chk_win("R10 quarter 0", quarter_of(snap, 0));
    step();
    chk_win("R10 quarter 1", quarter_of(snap, 1));
    step();
    chk_win("R9 quarter 2 held", quarter_of(snap, 2));
    step();
    chk_win("R10 quarter 3", quarter_of(snap, 3));
    chk_ctl("R5 pretrig ignored", 3'd6, 1'b1);
    pt = 1'b0;
    step();
    chk_ctl("R4 back to scan", 3'd1, 1'b0);
    chk_win("R8 scan live after cycle", '0);

    // R1: reset in the middle of a cycle
    pt = 1'b1;
    step();
    pt = 1'b0;
    step();
    rst_n = 1'b0;
    #2;
    chk_ctl("R1 mid-cycle reset", 3'd1, 1'b0);
    rst_n = 1'b1;
    step();
    chk_ctl("R2 after mid reset", 3'd1, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule